// File: doc/BRIEF.md
# Multi-Rate Serial Port with Register Interface

This block is an asynchronous serial transmitter and receiver behind four byte-wide registers. The host selects a bit rate from seven fixed rates, chooses one or two stop bits, optionally multiplies the rate by eight, and can force a break on the line. It sends a byte by writing the data register and collects a received byte by reading it. A status register reports the buffer flags, the line state and the error flags. Two flag outputs, transmit-empty and receive-available, drive a separate interrupt controller.

The rate generator divides the system clock down to a tick at sixteen times the bit rate. The transmitter and the receiver are each a small state machine clocked by that tick. The transmitter moves through `TX_IDLE` -> `TX_START` (on a tick with a byte waiting) -> `TX_DATA` (after 16 ticks) -> `TX_STOP` (after the last data bit). It then returns to `TX_IDLE` after one or two stop-bit periods. The receiver moves through `RX_IDLE` -> `RX_START` (on a tick seeing the line low). It then goes to `RX_DATA` if the line is still low at mid-start, or back to `RX_IDLE` if it is not. After the last data bit it goes to `RX_STOP`, and from there to `RX_IDLE` if the stop bit is high or to `RX_WAIT_HI` if it is low. `RX_WAIT_HI` returns to `RX_IDLE` once the line is high. A soft-reset command, or turning the rate off, sends both machines to idle.

Top module: `mrate_uart`

## Requirements
- R1: Register map on `addr`: 0 = status (read), 1 = rate select (write), 2 = command (write), 3 = data (read and write). Reads of addresses 1 and 2 return 0. After reset, status reads 0x84 with the line idle high, and `tx_line` is high.
- R2: Rate-select bits 0..6 choose 110, 150, 300, 1200, 2400, 4800 and 9600 baud. The highest set bit wins. One bit lasts 16 × floor(CLK_HZ / (16 × rate)) clock cycles.
- R3: Command bit 4 (high rate) divides the per-tick divisor by 8, so one bit lasts 16 × floor(divisor / 8) cycles.
- R4: With rate-select bits 0..6 all zero, the transmitter holds `tx_line` high and the receiver ignores the line. A byte written in this condition stays pending and is sent once a rate is enabled.
- R5: A frame is a low start bit, 8 data bits LSB first, then stop bits. Rate-select bit 7 = 1 gives one stop bit and 0 gives two. A byte queued during a frame starts one tick after the last stop bit, so the line stays high for (16 × stops + 1) ticks.
- R6: Status bit 7 (transmit empty, also `txe_flag`) clears on a data write. It sets again when the frame ends and no byte is waiting.
- R7: The receiver samples at 16 ticks per bit and confirms the start bit at mid-bit. A completed byte goes to the data register and sets status bit 6 (`rda_flag`). A data read clears bit 6.
- R8: A byte completing while status bit 6 is set sets status bit 1 (overrun), and the new byte replaces the old one.
- R9: A stop bit sampled low sets status bit 0 (frame error) and still delivers the byte. The receiver then waits for the line to return high before looking for the next start bit.
- R10: Command bit 1 (break) forces `tx_line` low for as long as it is set.
- R11: A command write with bit 0 set aborts any frame in progress. It clears status bits 6, 5, 1 and 0, drops a pending transmit byte, and leaves status bit 7 set.
- R12: Status bit 5 (interrupt pending) sets when a frame is sent or received. A data read, a data write or a soft reset clears it.
- R13: Status bit 2 follows the synchronized receive line. Bit 4 is set while the receiver is inside a frame, and bit 3 is set once all data bits are in and the stop bit is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (side effects on data reads) |
| rd_data | output | 8 | Read data, combinational from `addr` |
| rx_line | input | 1 | Serial receive line |
| tx_line | output | 1 | Serial transmit line |
| txe_flag | output | 1 | Transmit buffer empty |
| rda_flag | output | 1 | Received byte available |

## Verification
A tick counter off by one shows as a start bit of the wrong length on `tx_line` within the first bit of a frame. A transmit state machine that skips or repeats a state corrupts the byte or the stop-gap seen by the decoding monitor within one frame. A receiver that re-arms too early after a low stop bit produces a phantom byte, which shows as overrun within one further frame time. Flag errors, such as a transmit-empty or interrupt-pending bit left stale, show at the next status read, two cycles after the write or read that should have changed them.

// File: rtl/mrate_uart_pkg.sv
package mrate_uart_pkg;
    localparam int NRATES = 7;
    localparam int DBITS  = 8;
    localparam int OVS    = 16;
    localparam int TCW    = $clog2(OVS);
    localparam int BCW    = $clog2(DBITS);

    typedef enum logic [1:0] {
        A_STAT = 2'd0,
        A_RATE = 2'd1,
        A_CMD  = 2'd2,
        A_DATA = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HI} rx_state_e;

    function automatic int rate_baud(input int idx);
        case (idx)
            0: return 110;
            1: return 150;
            2: return 300;
            3: return 1200;
            4: return 2400;
            5: return 4800;
            default: return 9600;
        endcase
    endfunction
endpackage

// File: rtl/mrate_uart_baud.sv
module mrate_uart_baud
    import mrate_uart_pkg::*;
#(
    parameter int unsigned CLK_HZ = 14_745_600,
    parameter int          DIV_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NRATES-1:0] rate_bits,
    input  logic              hbaud,
    output logic              en,
    output logic              tick
);
    logic [DIV_W-1:0] div_tab [NRATES];
    logic [DIV_W-1:0] div_sel, div_eff, limit, cnt;
    logic [2:0]       sel;

    for (genvar i = 0; i < NRATES; i++) begin : g_div
        assign div_tab[i] = DIV_W'(CLK_HZ / (OVS * rate_baud(i)));
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < NRATES; i++) begin
            if (rate_bits[i]) sel = 3'(i);
        end
    end

    assign en      = |rate_bits;
    assign div_sel = div_tab[sel];
    assign div_eff = hbaud ? (div_sel >> 3) : div_sel;
    assign limit   = (div_eff == '0) ? '0 : div_eff - 1'b1;
    assign tick    = en && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n || !en)     cnt <= '0;
        else if (cnt >= limit) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mrate_uart_tx.sv
module mrate_uart_tx
    import mrate_uart_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             en,
    input  logic             tick,
    input  logic             req,
    input  logic [DBITS-1:0] data,
    input  logic             two_stop,
    output logic             take,
    output logic             done,
    output logic             busy,
    output logic             line
);
    tx_state_e        state, nxt;
    logic [TCW-1:0]   tcnt;
    logic [BCW-1:0]   bidx;
    logic [DBITS-1:0] sh;
    logic             stop2;
    logic             run, last_tick;

    assign run       = en && !abort;
    assign last_tick = tick && (tcnt == TCW'(OVS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) state <= TX_IDLE;
        else                state <= nxt;
    end

    always_comb begin
        nxt  = state;
        take = 1'b0;
        done = 1'b0;
        unique case (state)
            TX_IDLE:  if (run && tick && req) begin
                          nxt  = TX_START;
                          take = 1'b1;
                      end
            TX_START: if (last_tick) nxt = TX_DATA;
            TX_DATA:  if (last_tick && bidx == BCW'(DBITS - 1)) nxt = TX_STOP;
            TX_STOP:  if (run && last_tick && (!two_stop || stop2)) begin
                          nxt  = TX_IDLE;
                          done = 1'b1;
                      end
            default:  nxt = TX_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            TX_START: line = 1'b0;
            TX_DATA:  line = sh[0];
            default:  line = 1'b1;
        endcase
        busy = (state != TX_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tcnt  <= '0;
            bidx  <= '0;
            stop2 <= 1'b0;
            sh    <= '0;
        end else if (take) begin
            tcnt  <= '0;
            bidx  <= '0;
            stop2 <= 1'b0;
            sh    <= data;
        end else if (tick && state != TX_IDLE) begin
            tcnt <= tcnt + 1'b1;
            if (last_tick && state == TX_DATA) begin
                sh   <= sh >> 1;
                bidx <= bidx + 1'b1;
            end
            if (last_tick && state == TX_STOP) stop2 <= !stop2;
        end
    end
endmodule

// File: rtl/mrate_uart_rx.sv
module mrate_uart_rx
    import mrate_uart_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             en,
    input  logic             tick,
    input  logic             rxd,
    output logic             done,
    output logic             ferr,
    output logic [DBITS-1:0] rx_byte,
    output logic             in_frame,
    output logic             full
);
    rx_state_e        state, nxt;
    logic [TCW-1:0]   tcnt;
    logic [BCW-1:0]   bidx;
    logic [DBITS-1:0] sh;
    logic             run, last_tick, mid_tick;

    assign run       = en && !abort;
    assign last_tick = tick && (tcnt == TCW'(OVS - 1));
    assign mid_tick  = tick && (tcnt == TCW'(OVS / 2 - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) state <= RX_IDLE;
        else                state <= nxt;
    end

    always_comb begin
        nxt  = state;
        done = 1'b0;
        ferr = 1'b0;
        unique case (state)
            RX_IDLE:    if (tick && !rxd) nxt = RX_START;
            RX_START:   if (mid_tick) nxt = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:    if (last_tick && bidx == BCW'(DBITS - 1)) nxt = RX_STOP;
            RX_STOP:    if (last_tick) begin
                            done = run;
                            ferr = !rxd;
                            nxt  = rxd ? RX_IDLE : RX_WAIT_HI;
                        end
            RX_WAIT_HI: if (rxd) nxt = RX_IDLE;
            default:    nxt = RX_IDLE;
        endcase
    end

    assign in_frame = (state == RX_START) || (state == RX_DATA) || (state == RX_STOP);
    assign full     = (state == RX_STOP);
    assign rx_byte  = sh;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tcnt <= '0;
            bidx <= '0;
        end else if (tick) begin
            unique case (state)
                RX_START: tcnt <= (tcnt == TCW'(OVS / 2 - 1)) ? '0 : tcnt + 1'b1;
                RX_DATA: begin
                    tcnt <= tcnt + 1'b1;
                    if (last_tick) begin
                        sh   <= {rxd, sh[DBITS-1:1]};
                        bidx <= bidx + 1'b1;
                    end
                end
                RX_STOP:  tcnt <= tcnt + 1'b1;
                default:  tcnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/mrate_uart.sv
module mrate_uart
    import mrate_uart_pkg::*;
#(
    parameter int unsigned CLK_HZ = 14_745_600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    input  logic       rx_line,
    output logic       tx_line,
    output logic       txe_flag,
    output logic       rda_flag
);
    localparam int DIV_W = $clog2(CLK_HZ / (OVS * rate_baud(0)) + 1);

    logic [7:0]       rate_q;
    logic             hbaud_q, brk_q;
    logic [DBITS-1:0] tx_buf, rx_buf, rx_byte;
    logic             tx_req, rda_q, ov_q, fe_q, int_q;
    logic             rx_s1, rx_s2;
    logic             rate_en, tick, soft_rst;
    logic             wr_rate, wr_cmd, wr_dat, rd_dat;
    logic             take, tx_done, tx_busy, tx_raw;
    logic             rx_done, rx_ferr, in_frame, full;

    assign wr_rate  = wr_en && addr == A_RATE;
    assign wr_cmd   = wr_en && addr == A_CMD;
    assign wr_dat   = wr_en && addr == A_DATA;
    assign rd_dat   = rd_en && addr == A_DATA;
    assign soft_rst = wr_cmd && wr_data[0];

    mrate_uart_baud #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .rate_bits(rate_q[NRATES-1:0]),
        .hbaud(hbaud_q), .en(rate_en), .tick(tick)
    );

    mrate_uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .abort(soft_rst), .en(rate_en), .tick(tick),
        .req(tx_req), .data(tx_buf), .two_stop(!rate_q[7]),
        .take(take), .done(tx_done), .busy(tx_busy), .line(tx_raw)
    );

    mrate_uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .abort(soft_rst), .en(rate_en), .tick(tick),
        .rxd(rx_s2), .done(rx_done), .ferr(rx_ferr), .rx_byte(rx_byte),
        .in_frame(in_frame), .full(full)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q  <= '0;
            hbaud_q <= 1'b0;
            brk_q   <= 1'b0;
            tx_buf  <= '0;
            rx_buf  <= '0;
            tx_req  <= 1'b0;
            rda_q   <= 1'b0;
            ov_q    <= 1'b0;
            fe_q    <= 1'b0;
            int_q   <= 1'b0;
            rx_s1   <= 1'b1;
            rx_s2   <= 1'b1;
        end else begin
            rx_s1 <= rx_line;
            rx_s2 <= rx_s1;
            if (wr_rate) rate_q <= wr_data;
            if (wr_cmd) begin
                hbaud_q <= wr_data[4];
                brk_q   <= wr_data[1];
            end
            if (wr_dat) tx_buf <= wr_data;
            if (rx_done) rx_buf <= rx_byte;

            if (soft_rst)    tx_req <= 1'b0;
            else if (wr_dat) tx_req <= 1'b1;
            else if (take)   tx_req <= 1'b0;

            if (soft_rst)     rda_q <= 1'b0;
            else if (rx_done) rda_q <= 1'b1;
            else if (rd_dat)  rda_q <= 1'b0;

            if (soft_rst)                 ov_q <= 1'b0;
            else if (rx_done && rda_q)    ov_q <= 1'b1;

            if (soft_rst)                 fe_q <= 1'b0;
            else if (rx_done && rx_ferr)  fe_q <= 1'b1;

            if (soft_rst)                 int_q <= 1'b0;
            else if (rx_done || tx_done)  int_q <= 1'b1;
            else if (rd_dat || wr_dat)    int_q <= 1'b0;
        end
    end

    assign txe_flag = !tx_req && !tx_busy;
    assign rda_flag = rda_q;
    assign tx_line  = tx_raw && !brk_q;

    always_comb begin
        unique case (addr)
            A_STAT:  rd_data = {txe_flag, rda_q, int_q, in_frame, full, rx_s2, ov_q, fe_q};
            A_DATA:  rd_data = rx_buf;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mrate_uart_chk.sv
module mrate_uart_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] addr,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       rd_en,
    input logic       tx_line,
    input logic       txe_flag,
    input logic       rda_flag,
    input logic       rate_en,
    input logic       brk_q,
    input logic       rx_done,
    input logic       ov_q
);
    a_r10_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk_q |-> !tx_line);

    a_r4_off_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!rate_en && $past(!rate_en) && !brk_q) |-> tx_line);

    a_r6_write_clears_txe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3) |=> !txe_flag);

    a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2 && wr_data[0]) |=> (txe_flag && !rda_flag && !ov_q));

    a_r7_done_sets_rda: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rda_flag);

    a_r7_read_clears_rda: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd3 && !rx_done && !wr_en) |=> !rda_flag);

    a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rda_flag) |=> ov_q);
endmodule

bind mrate_uart mrate_uart_chk u_chk (.*);

// File: tb/mrate_uart_bench.sv
module mrate_uart_bench;
    localparam int unsigned CLK_HZ = 7_372_800;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rx_drv = 1'b1;
    logic       tx_line, txe_flag, rda_flag;

    int vectors = 0;
    int miscompares = 0;
    int bit_cyc = 768;
    logic mon_en = 1'b1;
    logic [7:0] exp_q[$];

    always #2.5 clk = !clk;

    mrate_uart #(.CLK_HZ(CLK_HZ)) u_mrate_uart (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rx_line(rx_drv), .tx_line(tx_line),
        .txe_flag(txe_flag), .rda_flag(rda_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // driver: queue the expected frame, then write the byte
    task automatic send_tx(input logic [7:0] b);
        exp_q.push_back(b);
        wr(2'd3, b);
    endtask

    task automatic wait_q_empty();
        while (exp_q.size() != 0) @(negedge clk);
        wait_cyc(bit_cyc);
    endtask

    task automatic wait_fall();
        logic p;
        @(negedge clk);
        p = tx_line;
        forever begin
            @(negedge clk);
            if (p && !tx_line) break;
            p = tx_line;
        end
    endtask

    task automatic count_low(output int n);
        n = 1;
        forever begin
            @(negedge clk);
            if (tx_line) break;
            n++;
        end
    endtask

    task automatic count_high(output int n);
        forever begin
            @(negedge clk);
            if (tx_line) break;
        end
        n = 1;
        forever begin
            @(negedge clk);
            if (!tx_line) break;
            n++;
        end
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop_hi, input int extra_low);
        @(negedge clk);
        rx_drv = 1'b0;
        wait_cyc(bit_cyc);
        for (int i = 0; i < 8; i++) begin
            rx_drv = b[i];
            wait_cyc(bit_cyc);
        end
        rx_drv = stop_hi;
        wait_cyc(bit_cyc);
        if (!stop_hi) wait_cyc(extra_low * bit_cyc);
        rx_drv = 1'b1;
        wait_cyc(bit_cyc);
    endtask

    task automatic measure_gap(output int n);
        send_tx(8'h55);
        wait_fall();
        send_tx(8'h55);
        wait_cyc(bit_cyc * 17 / 2 - 2);
        count_high(n);
    endtask

    // monitor: decode frames on tx_line and compare with the scoreboard queue
    initial begin : monitor
        logic p;
        logic [7:0] got;
        int bc;
        p = 1'b1;
        forever begin
            @(negedge clk);
            if (mon_en && p === 1'b1 && tx_line === 1'b0) begin
                bc = bit_cyc;
                repeat (bc / 2) @(negedge clk);
                chk("R5 start bit", tx_line, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (bc) @(negedge clk);
                    got[i] = tx_line;
                end
                repeat (bc) @(negedge clk);
                chk("R5 stop bit", tx_line, 1);
                if (exp_q.size() == 0) begin
                    vectors++;
                    miscompares++;
                    $display("FAIL R5 unexpected frame actual=%0h expected=none", got);
                end else begin
                    chk("R5 frame data", got, exp_q.pop_front());
                end
            end
            p = tx_line;
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        int n;
        bit held;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state and register map
        rd(2'd0, v); chk("R1 reset status", v, 8'h84);
        chk("R1 tx idle", tx_line, 1);
        rd(2'd1, v); chk("R1 rate reg reads zero", v, 8'h00);

        // R2 9600 baud, one stop bit; R6 txe clears on write
        wr(2'd1, 8'hC0);
        bit_cyc = 768;
        send_tx(8'h55);
        rd(2'd0, v); chk("R6 txe cleared by write", v[7], 0);
        wait_fall(); count_low(n); chk("R2 9600 bit length", n, 768);
        wait_q_empty();
        rd(2'd0, v); chk("R6 R12 txe and int after frame", v, 8'hA4);

        // R2 highest set bit wins (4800 over 110)
        wr(2'd1, 8'hA1);
        bit_cyc = 1536;
        send_tx(8'h55);
        wait_fall(); count_low(n); chk("R2 highest rate wins", n, 1536);
        wait_q_empty();

        // R3 high-rate multiplier
        wr(2'd1, 8'hC0);
        wr(2'd2, 8'h10);
        bit_cyc = 96;
        send_tx(8'h55);
        wait_fall(); count_low(n); chk("R3 x8 bit length", n, 96);
        wait_q_empty();
        send_tx(8'hA3);
        wait_q_empty();
        wr(2'd2, 8'h00);

        // R5 stop-bit count and queued-frame gap
        bit_cyc = 768;
        measure_gap(n); chk("R5 one stop gap", n, 816);
        wait_q_empty();
        wr(2'd1, 8'h40);
        measure_gap(n); chk("R5 two stop gap", n, 1584);
        wait_q_empty();
        wr(2'd1, 8'hC0);

        // R7 receive and read-clear, R12 read clears interrupt pending
        send_rx(8'h3C, 1'b1, 0);
        wait_cyc(4);
        rd(2'd0, v); chk("R7 rda set", v, 8'hE4);
        rd(2'd3, v); chk("R7 received byte", v, 8'h3C);
        rd(2'd0, v); chk("R7 R12 rda and int cleared by read", v, 8'h84);

        // R13 receiver frame-progress bits
        fork
            send_rx(8'hF0, 1'b1, 0);
            begin
                wait_cyc(bit_cyc * 5);
                rd(2'd0, v); chk("R13 in-frame bit", v & 8'h18, 8'h10);
                wait_cyc(bit_cyc * 4 + bit_cyc / 5 - 2);
                rd(2'd0, v); chk("R13 full bit", v & 8'h18, 8'h18);
            end
        join
        rd(2'd3, v); chk("R7 second byte", v, 8'hF0);

        // R8 overrun
        send_rx(8'h11, 1'b1, 0);
        send_rx(8'h22, 1'b1, 0);
        rd(2'd0, v); chk("R8 overrun status", v, 8'hE6);
        rd(2'd3, v); chk("R8 newer byte kept", v, 8'h22);

        // R11 soft reset clears flags
        wr(2'd2, 8'h01);
        rd(2'd0, v); chk("R11 soft reset status", v, 8'h84);

        // R9 frame error, no phantom byte while line stays low
        send_rx(8'h5A, 1'b0, 3);
        wait_cyc(bit_cyc);
        rd(2'd0, v); chk("R9 frame error only", v, 8'hE5);
        rd(2'd3, v); chk("R9 byte delivered", v, 8'h5A);
        wr(2'd2, 8'h01);

        // R13 line level and R4 disabled link
        wr(2'd1, 8'h00);
        rx_drv = 1'b0;
        wait_cyc(10);
        rd(2'd0, v); chk("R13 line level low", v, 8'h80);
        rx_drv = 1'b1;
        wait_cyc(10);
        send_rx(8'h77, 1'b1, 0);
        rd(2'd0, v); chk("R4 receiver ignores line", v, 8'h84);
        send_tx(8'h66);
        held = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!tx_line) held = 1'b0;
        end
        chk("R4 tx held high while off", held, 1);
        rd(2'd0, v); chk("R4 byte pending", v, 8'h04);
        wr(2'd1, 8'hC0);
        wait_q_empty();
        chk("R4 pending byte sent", exp_q.size(), 0);

        // R12 interrupt pending across a transmit
        send_tx(8'h81);
        rd(2'd0, v); chk("R12 int cleared by write", v, 8'h04);
        wait_q_empty();
        rd(2'd0, v); chk("R12 int set after send", v, 8'hA4);
        wr(2'd2, 8'h01);
        rd(2'd0, v); chk("R11 reset clears int", v, 8'h84);

        // R10 break
        mon_en = 1'b0;
        wr(2'd2, 8'h02);
        wait_cyc(5);
        chk("R10 break holds low", tx_line, 0);
        wr(2'd2, 8'h00);
        wait_cyc(2);
        chk("R10 break released", tx_line, 1);

        // R11 abort of a frame in progress
        wr(2'd3, 8'h00);
        wait_fall();
        wait_cyc(100);
        wr(2'd2, 8'h01);
        wait_cyc(2);
        chk("R11 abort returns line high", tx_line, 1);
        rd(2'd0, v); chk("R11 abort status", v, 8'h84);
        held = 1'b1;
        for (int i = 0; i < 2 * bit_cyc; i++) begin
            @(negedge clk);
            if (!tx_line) held = 1'b0;
        end
        chk("R11 no resend after abort", held, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule